// File: doc/BRIEF.md
# SD Card Bus Clock Divider

This block derives the SD card bus clock from a fast input clock. The ratio is a power of two from 1 to 512. Software selects it with an 8-bit divider code and a clock-enable bit. Two further inputs settle what the all-ones code means. A strap says whether the undivided setting is built in, and a double-data-rate mode input forbids it while active. The output is gated, and it starts and stops only while it is low.

A change of setting always follows the same order. The block gates the output off at its next low phase, loads the new ratio, and then ungates it if the enable bit is set. The counter restarts on every load, so the first period after enable is a full period. A ready output is high when the block can take a new write and low while a change is in progress. Writes that arrive while ready is low are dropped.

A combinational rate helper turns a requested bus rate and the source rate into a divider code. It picks the fastest output that does not exceed the request. A zero request is flagged so that software keeps the clock disabled.

Top module: `sdclk_div`

## Requirements
- R1: After reset, ready_o is 1, sd_clk_o is 0, and the output stays low until a write with the enable bit set.
- R2: A code with only bit b set (b = 0..7) gives divide by 2^(b+2): bit 7 is /512 and bit 0 is /4. The output is high for half the period and low for half.
- R3: Code 0x00 gives divide by 2. A code with several bits set, other than 0xFF, is governed by its highest set bit alone.
- R4: Code 0xFF with div1_strap_i=1 and ddr_mode_i=0 at the time of the write gives divide by 1. In that mode sd_clk_o follows clk_i.
- R5: Code 0xFF written while ddr_mode_i=1 or div1_strap_i=0 gives divide by 2.
- R6: An accepted write (wr_i while ready_o=1) drops ready_o in the following cycle. ready_o returns only after the output has stopped low and the new ratio is loaded. With enable set, the first rising edge of a divided output comes H+1 cycles after the cycle in which ready_o returns, where H is the half-period in input cycles.
- R7: A write presented while ready_o=0 is ignored. The ratio loaded is the one from the accepted write.
- R8: A write with wr_en_i=0 leaves sd_clk_o low and returns ready_o to 1.
- R9: A write accepted while the output is high does not shorten that high phase. It lasts its full H cycles.
- R10: The helper returns the code for the largest n in 0..9 with (src/512)*2^n <= request, using n=0 when even n=0 exceeds the request. The code is 0x80>>n for n<=7 and 0x00 for n=8. calc_off_o is 1 exactly when the request is 0.
- R11: For n=9 the helper returns 0xFF if div1_strap_i=1 and ddr_mode_i=0, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe for code and enable |
| wr_code_i | input | 8 | Divider code |
| wr_en_i | input | 1 | Output clock enable written with the code |
| ddr_mode_i | input | 1 | Double-data-rate mode; forbids divide by 1 |
| div1_strap_i | input | 1 | Divide-by-1 option is present |
| src_rate_i | input | RATE_W | Source clock rate for the helper |
| req_rate_i | input | RATE_W | Requested bus rate for the helper |
| sd_clk_o | output | 1 | Gated, divided bus clock |
| ready_o | output | 1 | High when idle and able to take a write |
| calc_code_o | output | 8 | Helper result code |
| calc_off_o | output | 1 | Helper: request is zero, keep clock off |

## Verification
Every result is timed from the cycle in which ready_o returns high. For a divided output, the bench expects the first high sample H+1 samples later. It then expects exactly H high samples and H low samples. All samples are taken 5 ns after the rising edge, so each registered change is settled when it is read. For divide by 1 the bench samples both clock phases, starting three cycles after ready returns; by then the falling-edge gate has opened. Ready must drop at the sample right after an accepted write. The helper is purely combinational, so its outputs are checked 1 ns after the inputs settle.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned MAX_LOG2 = CODE_W + 1;
  localparam int unsigned LOG_W    = $clog2(MAX_LOG2 + 1);

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LOG_W-1:0]  log2_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_LOAD  = 2'd2
  } seq_state_e;

  // Divider code to log2 of the ratio. All-ones is bypass when allowed.
  function automatic log2_t code_to_log2(input code_t code, input logic div1_ok);
    log2_t r;
    r = log2_t'(1);
    if (&code) begin
      r = div1_ok ? log2_t'(0) : log2_t'(1);
    end else begin
      for (int b = 0; b < CODE_W; b++) begin
        if (code[b]) r = log2_t'(b + 2);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/sdclk_rate_calc.sv
module sdclk_rate_calc
  import sdclk_pkg::*;
#(
  parameter int unsigned RATE_W = 32
) (
  input  logic [RATE_W-1:0] src_rate_i,
  input  logic [RATE_W-1:0] req_rate_i,
  input  logic              ddr_mode_i,
  input  logic              div1_strap_i,
  output code_t             code_o,
  output logic              off_o
);
  localparam int unsigned EXT_W = RATE_W + 2;
  localparam int unsigned STEP_W = $clog2(MAX_LOG2 + 1);

  logic [EXT_W-1:0]  cur;
  logic [EXT_W-1:0]  req_ext;
  logic [STEP_W-1:0] steps;
  logic              go;

  always_comb begin
    req_ext = EXT_W'(req_rate_i);
    cur     = EXT_W'(src_rate_i) >> MAX_LOG2;
    steps   = '0;
    go      = 1'b1;
    for (int i = 0; i < MAX_LOG2; i++) begin
      if (go && (req_ext >= (cur << 1))) begin
        cur   = cur << 1;
        steps = steps + 1'b1;
      end else begin
        go = 1'b0;
      end
    end
  end

  always_comb begin
    if (steps < STEP_W'(CODE_W)) begin
      code_o = code_t'({1'b1, {(CODE_W-1){1'b0}}}) >> steps;
    end else if (steps == STEP_W'(CODE_W)) begin
      code_o = '0;
    end else begin
      code_o = (div1_strap_i && !ddr_mode_i) ? '1 : '0;
    end
    off_o = (req_rate_i == '0);
  end

  always_comb begin
    assert_code_legal_R10: assert ($onehot0(code_o) || (&code_o))
      else $error("helper code is neither one-hot, zero nor all-ones");
  end
endmodule

// File: rtl/sdclk_seq.sv
module sdclk_seq
  import sdclk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  code_t wr_code_i,
  input  logic  wr_en_i,
  input  logic  ddr_mode_i,
  input  logic  div1_strap_i,
  input  logic  stopped_i,
  output logic  run_req_o,
  output logic  load_o,
  output log2_t ratio_o,
  output logic  ready_o
);
  seq_state_e state_q, state_d;
  logic       en_q, en_d;
  log2_t      pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    en_d    = en_q;
    pend_d  = pend_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (wr_i) begin
          pend_d  = code_to_log2(wr_code_i, div1_strap_i & ~ddr_mode_i);
          en_d    = wr_en_i;
          state_d = SEQ_DRAIN;
        end
      end
      SEQ_DRAIN: begin
        if (stopped_i) state_d = SEQ_LOAD;
      end
      SEQ_LOAD: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      en_q    <= 1'b0;
      pend_q  <= log2_t'(MAX_LOG2);
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
    end
  end

  assign ready_o   = (state_q == SEQ_IDLE);
  assign run_req_o = (state_q == SEQ_IDLE) && en_q;
  assign load_o    = (state_q == SEQ_LOAD);
  assign ratio_o   = pend_q;

  assert_busy_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ready_o) |=> !ready_o)
    else $error("ready stayed high after an accepted write");

  assert_ignore_busy_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_IDLE) |=> $stable(pend_q))
    else $error("pending ratio changed during a change sequence");
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_req_i,
  input  logic  load_i,
  input  log2_t ratio_i,
  output logic  sd_clk_o,
  output logic  stopped_o
);
  localparam int unsigned CNT_W = CODE_W;

  logic             run_q, run_d;
  logic             div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  log2_t            ratio_q, ratio_d;
  logic             gate_q;
  logic             bypass;
  logic [CNT_W:0]   half_w;
  logic [CNT_W-1:0] last;

  assign bypass = (ratio_q == '0);

  always_comb begin
    half_w = (CNT_W+1)'(1) << (ratio_q - log2_t'(1));
    last   = CNT_W'(half_w - 1'b1);
  end

  always_comb begin
    run_d   = run_q;
    div_d   = div_q;
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    if (load_i && !run_q) ratio_d = ratio_i;
    if (!run_q) begin
      cnt_d = '0;
      div_d = 1'b0;
      if (run_req_i) run_d = 1'b1;
    end else if (!run_req_i && !div_q) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (!bypass) begin
      if (cnt_q == last) begin
        cnt_d = '0;
        div_d = ~div_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      div_q   <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= log2_t'(MAX_LOG2);
    end else begin
      run_q   <= run_d;
      div_q   <= div_d;
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

  // Bypass gate changes only while the input clock is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= run_q & bypass;
  end

  assign sd_clk_o  = bypass ? (clk_i & gate_q) : div_q;
  assign stopped_o = ~run_q;

  assert_low_when_stopped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !div_q)
    else $error("divided clock high while stopped");

  assert_stop_on_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> !$past(div_q))
    else $error("output stopped during a high phase");

  assert_fall_only_running_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_q) |-> $past(run_q))
    else $error("divided clock fell while not running");
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
#(
  parameter int unsigned RATE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wr_code_i,
  input  logic              wr_en_i,
  input  logic              ddr_mode_i,
  input  logic              div1_strap_i,
  input  logic [RATE_W-1:0] src_rate_i,
  input  logic [RATE_W-1:0] req_rate_i,
  output logic              sd_clk_o,
  output logic              ready_o,
  output logic [7:0]        calc_code_o,
  output logic              calc_off_o
);
  logic  run_req;
  logic  load;
  logic  stopped;
  log2_t ratio;

  sdclk_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .wr_code_i    (wr_code_i),
    .wr_en_i      (wr_en_i),
    .ddr_mode_i   (ddr_mode_i),
    .div1_strap_i (div1_strap_i),
    .stopped_i    (stopped),
    .run_req_o    (run_req),
    .load_o       (load),
    .ratio_o      (ratio),
    .ready_o      (ready_o)
  );

  sdclk_gen i_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_req_i (run_req),
    .load_i    (load),
    .ratio_i   (ratio),
    .sd_clk_o  (sd_clk_o),
    .stopped_o (stopped)
  );

  sdclk_rate_calc #(.RATE_W(RATE_W)) i_calc (
    .src_rate_i   (src_rate_i),
    .req_rate_i   (req_rate_i),
    .ddr_mode_i   (ddr_mode_i),
    .div1_strap_i (div1_strap_i),
    .code_o       (calc_code_o),
    .off_o        (calc_off_o)
  );

  assert_load_while_stopped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |-> stopped)
    else $error("new ratio loaded while the output was running");
endmodule

// File: tb/test_sdclk_div.sv
module test_sdclk_div;
  localparam int RATE_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr;
  logic [7:0]        wr_code;
  logic              wr_en;
  logic              ddr;
  logic              strap;
  logic [RATE_W-1:0] src_rate;
  logic [RATE_W-1:0] req_rate;
  logic              sd_clk;
  logic              ready;
  logic [7:0]        calc_code;
  logic              calc_off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdclk_div #(.RATE_W(RATE_W)) i_sdclk_div (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_code_i(wr_code), .wr_en_i(wr_en),
    .ddr_mode_i(ddr), .div1_strap_i(strap), .src_rate_i(src_rate), .req_rate_i(req_rate),
    .sd_clk_o(sd_clk), .ready_o(ready), .calc_code_o(calc_code), .calc_off_o(calc_off)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  function automatic int exp_log2(input logic [7:0] code, input bit s, input bit d);
    int r = 1;
    if (code == 8'hFF) return (s && !d) ? 0 : 1;
    for (int b = 7; b >= 0; b--) begin
      if (code[b]) return b + 2;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_code(input longint src, input longint rq, input bit s, input bit d);
    int n = 0;
    longint base = src / 512;
    for (int k = 0; k <= 9; k++) begin
      if ((base << k) <= rq) n = k;
    end
    if (n <= 7) return 8'h80 >> n;
    if (n == 8) return 8'h00;
    return (s && !d) ? 8'hFF : 8'h00;
  endfunction

  task automatic write(input logic [7:0] code, input bit en, input string req);
    wr_code = code;
    wr_en   = en;
    wr      = 1'b1;
    tick();
    wr      = 1'b0;
    check(ready == 1'b0, req, ready, 0);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 2000) begin
      tick();
      n++;
    end
    check(ready == 1'b1, req, ready, 1);
  endtask

  task automatic measure(input int k, input string req);
    if (k == 0) begin
      repeat (3) tick();
      for (int i = 0; i < 4; i++) begin
        check(sd_clk == 1'b1, req, sd_clk, 1);
        #10;
        check(sd_clk == 1'b0, req, sd_clk, 0);
        tick();
      end
    end else begin
      int h = 1 << (k - 1);
      int c = 0;
      int hi = 0;
      int lo = 0;
      while (sd_clk == 1'b0 && c < 2000) begin
        tick();
        c++;
      end
      check(c == h + 1, {req, " first rise"}, c, h + 1);
      while (sd_clk == 1'b1 && hi < 2000) begin
        tick();
        hi++;
      end
      check(hi == h, {req, " high"}, hi, h);
      while (sd_clk == 1'b0 && lo < 2000) begin
        tick();
        lo++;
      end
      check(lo == h, {req, " low"}, lo, h);
    end
  endtask

  task automatic run_code(input logic [7:0] code, input bit s, input bit d, input string req);
    strap = s;
    ddr   = d;
    write(code, 1'b1, req);
    wait_ready(req);
    measure(exp_log2(code, s, d), req);
  endtask

  task automatic calc_check(input longint src, input longint rq, input bit s, input bit d, input string req);
    logic [7:0] e;
    src_rate = RATE_W'(src);
    req_rate = RATE_W'(rq);
    strap = s;
    ddr   = d;
    #1;
    e = exp_code(src, rq, s, d);
    check(calc_code == e, req, calc_code, e);
    check(calc_off == (rq == 0), {req, " off"}, calc_off, rq == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr = 1'b0; wr_code = '0; wr_en = 1'b0; ddr = 1'b0; strap = 1'b1;
    src_rate = '0; req_rate = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    check(ready == 1'b1, "R1 ready", ready, 1);
    for (int i = 0; i < 20; i++) begin
      check(sd_clk == 1'b0, "R1 idle low", sd_clk, 0);
      tick();
    end

    // R2: one-hot codes
    run_code(8'h01, 1, 0, "R2 div4");
    run_code(8'h08, 1, 0, "R2 div32");
    run_code(8'h80, 1, 0, "R2 div512");
    // R3: zero and multi-bit codes
    run_code(8'h00, 1, 0, "R3 div2");
    run_code(8'h0B, 1, 0, "R3 multi-bit");
    // R4: bypass
    run_code(8'hFF, 1, 0, "R4 bypass");
    // R5: bypass forbidden
    run_code(8'hFF, 1, 1, "R5 ddr");
    run_code(8'hFF, 0, 0, "R5 no strap");

    // R9 and R7: write during high phase, second write ignored
    run_code(8'h40, 1, 0, "R2 div256");
    begin
      int hi = 1;
      while (sd_clk == 1'b0) tick();
      wr_code = 8'h01; wr_en = 1'b1; wr = 1'b1;
      tick();
      wr = 1'b0;
      check(ready == 1'b0, "R6 busy", ready, 0);
      if (sd_clk) hi++;
      wr_code = 8'h00; wr = 1'b1;
      tick();
      wr = 1'b0;
      if (sd_clk) hi++;
      while (sd_clk == 1'b1 && hi < 2000) begin
        tick();
        if (sd_clk) hi++;
      end
      check(hi == 128, "R9 full high", hi, 128);
      wait_ready("R6 ready returns");
      measure(2, "R7 ignored write");
    end

    // R8: enable off
    strap = 1; ddr = 0;
    write(8'h02, 1'b0, "R8 busy");
    wait_ready("R8 ready");
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        if (sd_clk) seen++;
        tick();
      end
      check(seen == 0, "R8 stays low", seen, 0);
    end

    // Random mix
    for (int it = 0; it < 10; it++) begin
      logic [7:0] c;
      int sel = int'($urandom % 4);
      case (sel)
        0: c = 8'h01 << ($urandom % 6);
        1: c = 8'h00;
        2: c = 8'hFF;
        default: c = 8'(($urandom % 60) + 3);
      endcase
      run_code(c, 1'($urandom % 2), 1'($urandom % 2), "R2 R3 R4 R5 random");
    end

    // R10 and R11: rate helper
    calc_check(200000000, 400000, 1, 0, "R10 slow");
    calc_check(200000000, 25000000, 1, 0, "R10 mid");
    calc_check(200000000, 100000000, 1, 0, "R10 div2");
    calc_check(200000000, 200000000, 1, 0, "R11 div1 allowed");
    calc_check(200000000, 200000000, 1, 1, "R11 ddr");
    calc_check(200000000, 200000000, 0, 0, "R11 no strap");
    calc_check(200000000, 100, 1, 0, "R10 below min");
    calc_check(200000000, 0, 1, 0, "R10 zero");
    calc_check(300, 5, 1, 0, "R11 tiny source");
    for (int it = 0; it < 20; it++) begin
      longint s = longint'($urandom % 32'd400000000) + 1000;
      longint q = longint'($urandom) % (s + 1);
      calc_check(s, q, 1'($urandom % 2), 1'($urandom % 2), "R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule